// File: doc/BRIEF.md
# Ternary CAM flow classifier

This block sorts packets into flows by searching a small ternary content-addressable store. A lookup presents five header fields: source and destination address, protocol, and source and destination port. The block packs them into one contiguous search key and compares that key against every slot at the same time. Each slot holds a stored pattern, a per-bit care mask and a valid flag. Bits whose mask bit is clear are don't-care, so one slot can describe an exact five-tuple, a single port, an address prefix or a catch-all rule.

The lookup reports the full vector of matching slots and the lowest-numbered matching slot, which is the winner. The winner's index reads a separate class memory that holds the flow identifier. When no slot matches, the block returns a fixed miss class. Lookups are pipelined over three clock edges and one may start on every cycle. A configuration port writes the pattern, mask, valid flag and class of one slot per cycle.

Top module: `flow_tcam_classifier`

## Requirements
- R1: After synchronous reset every slot is invalid and the outputs res_valid, res_hit, res_index and res_match are zero. A lookup issued after reset, before any configuration write, misses.
- R2: The search key is {lk_src_addr, lk_dst_addr, lk_proto, lk_src_port, lk_dst_port}, with the source address in the most significant bits. For the default widths that places the source address at bits 103:72, the destination address at 71:40, the protocol at 39:32, the source port at 31:16 and the destination port at 15:0. cfg_value and cfg_mask use the same layout.
- R3: A valid slot matches when (key & mask) == (value & mask). A mask bit of 1 makes that key bit take part in the comparison. A mask bit of 0 makes it don't-care.
- R4: A slot whose valid flag is 0 never matches, whatever its mask is. This includes a slot that was made invalid by writing cfg_valid=0 over a valid entry.
- R5: Bit i of res_match is 1 exactly when slot i matches the key of that lookup.
- R6: On a hit, res_hit is 1 and res_index is the lowest index among the matching slots.
- R7: On a hit, res_class is the class last written for the winning slot.
- R8: On a miss, res_hit is 0, res_index is 0, res_match is 0 and res_class is MISS_CLASS (8'hFF by default).
- R9: A lookup sampled with lk_valid=1 at a rising edge yields res_valid=1 for one cycle after the third rising edge that follows. Lookups on consecutive cycles give results on consecutive cycles, in issue order.
- R10: A configuration write sampled at a rising edge (cfg_we=1, slot cfg_idx) applies to every lookup sampled at that edge or at any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_src_addr | input | ADDR_W | Source address field |
| lk_dst_addr | input | ADDR_W | Destination address field |
| lk_proto | input | PROTO_W | Protocol field |
| lk_src_port | input | PORT_W | Source port field |
| lk_dst_port | input | PORT_W | Destination port field |
| cfg_we | input | 1 | Write one slot this cycle |
| cfg_idx | input | IDX_W | Slot to write |
| cfg_value | input | KEY_W | Stored pattern |
| cfg_mask | input | KEY_W | Care mask, 1 means compare |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_class | input | CLASS_W | Class to store for the slot |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | At least one slot matched |
| res_index | output | IDX_W | Lowest matching slot |
| res_class | output | CLASS_W | Class of the winner or MISS_CLASS |
| res_match | output | SLOTS | All matching slots |

## Verification
A corrupted pattern, mask or valid flag shows up in res_match on the first lookup whose key touches the damaged bits. That happens three edges after the lookup is issued, and the error also moves res_index whenever the damaged slot is the lowest match. A wrong class-memory word only appears when its slot wins, so each configured slot is made the winner at least once. A stuck pipeline valid shows up as a missing or extra strobe, which the scoreboard catches through an empty or non-empty queue and through a due-cycle comparison on every result.

// File: rtl/tcam_cls_pkg.sv
package tcam_cls_pkg;

  // Default field widths of the packed search key.
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned PROTO_W_DEF = 8;
  localparam int unsigned PORT_W_DEF  = 16;

  // Index width that stays legal for a single-entry array.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/flow_key_pack.sv
module flow_key_pack #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PROTO_W = 8,
  parameter int unsigned PORT_W  = 16,
  localparam int unsigned KEY_W  = 2*ADDR_W + PROTO_W + 2*PORT_W
) (
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  input  logic [PROTO_W-1:0] proto,
  input  logic [PORT_W-1:0]  src_port,
  input  logic [PORT_W-1:0]  dst_port,
  output logic [KEY_W-1:0]   key
);

  // Source address lands in the top bits, destination port in the bottom.
  assign key = {src_addr, dst_addr, proto, src_port, dst_port};

endmodule

// File: rtl/tcam_slot_array.sv
module tcam_slot_array #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned KEY_W = 104,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] key,
  output logic [SLOTS-1:0] hit_vec
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] msk_q;
    logic             vld_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(s));

    // Pattern and mask carry no reset; only the valid flag needs one.
    always_ff @(posedge clk) begin
      if (sel) begin
        val_q <= wr_value;
        msk_q <= wr_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)      vld_q <= 1'b0;
      else if (sel) vld_q <= wr_valid;
    end

    // Masked compare: only bits with mask=1 may differ to break the match.
    assign hit_vec[s] = vld_q && (((key ^ val_q) & msk_q) == '0);

    AST_CLEARED_SLOT_SILENT: assert property (@(posedge clk) disable iff (rst)
      (sel && !wr_valid) |=> !hit_vec[s]);  // R4
  end

endmodule

// File: rtl/first_match_enc.sv
module first_match_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/flow_class_ram.sv
module flow_class_ram #(
  parameter int unsigned       DEPTH  = 16,
  parameter int unsigned       DATA_W = 8,
  parameter int unsigned       ADDR_W = 4,
  parameter logic [DATA_W-1:0] MISS   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port; a miss substitutes the default class.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_hit ? mem[rd_addr] : MISS;
  end

endmodule

// File: rtl/flow_tcam_classifier.sv
module flow_tcam_classifier
  import tcam_cls_pkg::*;
#(
  parameter int unsigned        SLOTS      = 16,
  parameter int unsigned        ADDR_W     = ADDR_W_DEF,
  parameter int unsigned        PROTO_W    = PROTO_W_DEF,
  parameter int unsigned        PORT_W     = PORT_W_DEF,
  parameter int unsigned        CLASS_W    = 8,
  parameter logic [CLASS_W-1:0] MISS_CLASS = '1,
  localparam int unsigned       KEY_W      = 2*ADDR_W + PROTO_W + 2*PORT_W,
  localparam int unsigned       IDX_W      = idx_width(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_src_addr,
  input  logic [ADDR_W-1:0]  lk_dst_addr,
  input  logic [PROTO_W-1:0] lk_proto,
  input  logic [PORT_W-1:0]  lk_src_port,
  input  logic [PORT_W-1:0]  lk_dst_port,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [KEY_W-1:0]   cfg_value,
  input  logic [KEY_W-1:0]   cfg_mask,
  input  logic               cfg_valid,
  input  logic [CLASS_W-1:0] cfg_class,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_index,
  output logic [CLASS_W-1:0] res_class,
  output logic [SLOTS-1:0]   res_match
);

  logic [KEY_W-1:0] key_c, key_q;
  logic             s1_vld, s2_vld;
  logic [SLOTS-1:0] match_c, s2_match;
  logic             any_c, s2_any;
  logic [IDX_W-1:0] win_c, s2_idx;

  flow_key_pack #(.ADDR_W(ADDR_W), .PROTO_W(PROTO_W), .PORT_W(PORT_W)) u_pack (
    .src_addr(lk_src_addr), .dst_addr(lk_dst_addr), .proto(lk_proto),
    .src_port(lk_src_port), .dst_port(lk_dst_port), .key(key_c)
  );

  // Stage 1: capture the packed key.
  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= lk_valid;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) key_q <= key_c;
  end

  tcam_slot_array #(.SLOTS(SLOTS), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_value(cfg_value), .wr_mask(cfg_mask), .wr_valid(cfg_valid),
    .key(key_q), .hit_vec(match_c)
  );

  first_match_enc #(.N(SLOTS), .IDX_W(IDX_W)) u_enc (
    .vec(match_c), .any(any_c), .idx(win_c)
  );

  // Stage 2: capture the match vector and the encoded winner.
  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else     s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_match <= match_c;
      s2_any   <= any_c;
      s2_idx   <= win_c;
    end
  end

  // Stage 3: class read and result registers.
  flow_class_ram #(.DEPTH(SLOTS), .DATA_W(CLASS_W), .ADDR_W(IDX_W), .MISS(MISS_CLASS)) u_class (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_idx), .wr_data(cfg_class),
    .rd_en(s2_vld), .rd_hit(s2_any), .rd_addr(s2_idx), .rd_data(res_class)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_index <= '0;
      res_match <= '0;
    end else begin
      res_valid <= s2_vld;
      if (s2_vld) begin
        res_hit   <= s2_any;
        res_index <= s2_idx;
        res_match <= s2_match;
      end
    end
  end

  AST_HIT_AGREES_VECTOR: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit == (|res_match)));  // R5
  AST_WINNER_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (res_match[res_index] &&
      ((res_match & ((SLOTS'(1) << res_index) - SLOTS'(1))) == '0)));  // R6
  AST_MISS_GIVES_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_class == MISS_CLASS && res_index == '0));  // R8
  AST_THREE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(lk_valid, 3));  // R9

endmodule

// File: tb/flow_tcam_classifier_bench.sv
module flow_tcam_classifier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 16;
  localparam int KW         = 104;
  localparam int WATCHDOG   = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [31:0]   lk_src_addr = '0, lk_dst_addr = '0;
  logic [7:0]    lk_proto = '0;
  logic [15:0]   lk_src_port = '0, lk_dst_port = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [KW-1:0] cfg_value = '0, cfg_mask = '0;
  logic          cfg_valid = 1'b0;
  logic [7:0]    cfg_class = '0;
  logic          res_valid, res_hit;
  logic [3:0]    res_index;
  logic [7:0]    res_class;
  logic [15:0]   res_match;

  flow_tcam_classifier u_flow_tcam_classifier (
    .clk(clk), .rst(rst), .lk_valid(lk_valid),
    .lk_src_addr(lk_src_addr), .lk_dst_addr(lk_dst_addr), .lk_proto(lk_proto),
    .lk_src_port(lk_src_port), .lk_dst_port(lk_dst_port),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
    .cfg_valid(cfg_valid), .cfg_class(cfg_class),
    .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
    .res_class(res_class), .res_match(res_match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        hit;
    logic [3:0]  idx;
    logic [7:0]  cls;
    logic [15:0] mv;
    int          due;
    string       tag;
  } exp_t;

  exp_t          sb[$];
  exp_t          cur;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  bit            finished = 1'b0;
  logic [KW-1:0] m_val [SLOTS];
  logic [KW-1:0] m_msk [SLOTS];
  bit            m_vld [SLOTS];
  logic [7:0]    m_cls [SLOTS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (case %s) actual %0h expected %0h at cycle %0d", req, tag, act, exp, cyc);
    end
  endtask

  // R2: key layout {src_addr, dst_addr, proto, src_port, dst_port}
  function automatic logic [KW-1:0] mk(input logic [31:0] sa, input logic [31:0] da,
                                       input logic [7:0] pr, input logic [15:0] sp, input logic [15:0] dp);
    return {sa, da, pr, sp, dp};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid = 1'b0;
      cfg_we   = 1'b0;
    end
  endtask

  task automatic wr(input int idx, input logic [KW-1:0] val, input logic [KW-1:0] msk,
                    input bit vld, input logic [7:0] cls);
    @(negedge clk);
    lk_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_idx   = 4'(idx);
    cfg_value = val;
    cfg_mask  = msk;
    cfg_valid = vld;
    cfg_class = cls;
    m_val[idx] = val;
    m_msk[idx] = msk;
    m_vld[idx] = vld;
    m_cls[idx] = cls;
  endtask

  // Driver: computes the expected result from the reference tables and queues it.
  task automatic lookup(input logic [31:0] sa, input logic [31:0] da, input logic [7:0] pr,
                        input logic [15:0] sp, input logic [15:0] dp, input string tag);
    exp_t          e;
    logic [KW-1:0] k;
    k     = mk(sa, da, pr, sp, dp);
    e.mv  = '0;
    e.hit = 1'b0;
    e.idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (m_vld[s] && (((k ^ m_val[s]) & m_msk[s]) == '0)) begin
        e.mv[s] = 1'b1;
        e.hit   = 1'b1;
        e.idx   = 4'(s);
      end
    end
    e.cls = e.hit ? m_cls[e.idx] : 8'hFF;
    e.tag = tag;
    @(negedge clk);
    cfg_we      = 1'b0;
    lk_valid    = 1'b1;
    lk_src_addr = sa;
    lk_dst_addr = da;
    lk_proto    = pr;
    lk_src_port = sp;
    lk_dst_port = dp;
    e.due       = cyc + 3;
    sb.push_back(e);
  endtask

  // Monitor: pops and compares each result as it appears.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        chk("R9", "unexpected strobe", 32'(res_valid), 32'd0);
      end else begin
        cur = sb.pop_front();
        chk("R9", cur.tag, 32'(cyc), 32'(cur.due));
        chk("R5", cur.tag, 32'(res_match), 32'(cur.mv));
        chk("R6", cur.tag, 32'(res_hit), 32'(cur.hit));
        chk(cur.hit ? "R6" : "R8", cur.tag, 32'(res_index), 32'(cur.idx));
        chk(cur.hit ? "R7" : "R8", cur.tag, 32'(res_class), 32'(cur.cls));
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", WATCHDOG);
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      m_vld[s] = 1'b0;
      m_val[s] = '0;
      m_msk[s] = '0;
      m_cls[s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset", 32'(res_valid), 32'd0);
    chk("R1", "reset", 32'(res_hit), 32'd0);
    chk("R1", "reset", 32'(res_match), 32'd0);
    chk("R1", "reset", 32'(res_index), 32'd0);
    lookup(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1234, 16'd443, "R1");
    idle(5);

    // Exact five-tuple, port-only, catch-all, invalid catch-all, prefix, protocol-only.
    wr(5, mk(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1234, 16'd443), '1, 1'b1, 8'h21);
    wr(2, mk(32'h0, 32'h0, 8'h0, 16'h0, 16'd80), mk(32'h0, 32'h0, 8'h0, 16'h0, 16'hFFFF), 1'b1, 8'h42);
    wr(9, '0, '0, 1'b1, 8'h07);
    wr(12, '0, '0, 1'b0, 8'h33);
    wr(3, mk(32'h0A000000, 32'h0, 8'h0, 16'h0, 16'h0), {8'hFF, 96'h0}, 1'b1, 8'h3A);
    wr(7, mk(32'h0, 32'h0, 8'd17, 16'h0, 16'h0), {64'h0, 8'hFF, 32'h0}, 1'b1, 8'h55);

    // Back-to-back lookups covering distinct match patterns.
    lookup(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1234, 16'd443, "R3");
    lookup(32'h01020304, 32'hFFFF0000, 8'd6, 16'd999, 16'd80, "R3");
    lookup(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1235, 16'd443, "R3");
    lookup(32'h01020304, 32'h05060708, 8'd17, 16'd53, 16'd53, "R2");
    lookup(32'h0A0B0C0D, 32'h05060708, 8'd6, 16'd53, 16'd53, "R2");
    lookup(32'h0A0B0C0D, 32'h05060708, 8'd17, 16'd5, 16'd80, "R6");
    idle(5);

    // Clear the catch-all and rewrite a class, then re-run.
    wr(9, '0, '0, 1'b0, 8'h07);
    wr(2, mk(32'h0, 32'h0, 8'h0, 16'h0, 16'd80), mk(32'h0, 32'h0, 8'h0, 16'h0, 16'hFFFF), 1'b1, 8'h99);
    lookup(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1235, 16'd443, "R4");
    lookup(32'h01020304, 32'hFFFF0000, 8'd6, 16'd999, 16'd80, "R10");

    // Write immediately followed by a lookup that depends on it.
    wr(12, '0, '0, 1'b1, 8'h66);
    lookup(32'hC0A80001, 32'h0A000002, 8'd6, 16'd1235, 16'd443, "R10");
    lookup(32'h01020304, 32'hFFFF0000, 8'd1, 16'd7, 16'd7, "R10");
    idle(6);

    chk("R9", "drain", 32'(sb.size()), 32'd0);
    finish_run();
  end

endmodule